// File: doc/BRIEF.md
# Sixteen-Lane ADC Sample Correction and Buffering

This block takes raw signed 16-bit samples from sixteen ADC lanes and puts each one through a two-stage correction pipeline: a signed multiply by a per-lane Q1.15 gain, then a per-lane signed offset, with rounding and saturation. The corrected sample goes into a 16-entry FIFO that belongs to that lane. A free-running conversion timer produces a sample tick every N clock cycles, which tells the converter when to sample. The converter returns each sample through a per-lane valid strobe.

Software reaches the block through a simple register port. Writes take effect on the clock edge. A read returns its data on `reg_rdata` in the cycle after `reg_rd`. Reading a lane's data register removes the oldest corrected sample from that lane's FIFO. After reset every lane uses unity gain and zero offset, so raw samples pass through unchanged until software loads calibration values.

Top module: `adc_corr_buf`

## Requirements
- R1: After reset, every gain register reads 0x7FFF, every offset register reads 0, the period register reads 0, the overflow word reads 0, and every data register reads 0.
- R2: The register map uses reg_addr[7:4] as the group and reg_addr[3:0] as the lane or item. The groups are: 0x0 control (item 0 = period, item 4 = overflow word), 0x1 gain, 0x2 offset, 0x3 data. Read data appears on reg_rdata in the cycle after reg_rd, zero-extended to 32 bits.
- R3: For any gain other than 0x7FFF, the stored value is floor((s*g + o*32768 + 16384) / 32768). Here s is the sample, g is the gain and o is the offset, all signed 16-bit.
- R4: A gain of 0x7FFF means exactly 1.0. The stored value is then s + o, with no scaling loss.
- R5: A corrected result above 32767 is stored as 0x7FFF. A result below -32768 is stored as 0x8000.
- R6: Each lane keeps up to 16 samples. Reads of its data register return them oldest first, and each read removes the sample it returns.
- R7: A sample that arrives while its lane FIFO is full is discarded, and bit n of the overflow word is set for lane n. The bit stays set until software writes a 1 to it at the overflow-word address.
- R8: A data read from an empty lane returns 0 and does not disturb that lane's FIFO. The next sample written is the next one returned.
- R9: A sample whose adc_valid is high in cycle t is written to its FIFO at the end of cycle t+2. If a pop of a full FIFO lands in that same cycle, the sample is kept and no overflow is flagged.
- R10: When the period register holds N > 0, samp_tick is high for one cycle in every N cycles, first in the N-th cycle after the write. When it holds 0, samp_tick stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_tick | output | 1 | Conversion request pulse from the timer |
| adc_valid | input | 16 | Per-lane sample-valid strobe |
| adc_data | input | 256 | Lane n sample in bits [16n+15:16n], signed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |

## Verification
A FIFO push coming out of the correction pipeline and a software pop from the same lane can land in one cycle. This matters most when the lane is full. The bench fills a lane to sixteen entries, raises adc_valid, and two cycles later issues a data read of that lane so that the pop lands on the write edge. It then requires three things: the read returns the oldest entry, the overflow bit stays clear, and draining the lane yields the fifteen remaining old samples followed by the new one. Because the timing is so tight, a pipeline one cycle longer or shorter, or a full test that ignores the pop, shows up as a wrong sample order or a set overflow bit.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // Address group held in reg_addr[7:4]
  typedef enum logic [3:0] {
    GRP_CTRL = 4'h0,
    GRP_GAIN = 4'h1,
    GRP_OFFS = 4'h2,
    GRP_DATA = 4'h3
  } reg_grp_e;

  localparam logic [3:0] CTRL_PERIOD = 4'h0;
  localparam logic [3:0] CTRL_OVF    = 4'h4;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  input  logic          load,
  output logic          tick
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (load || period == '0) begin
      cnt_d = '0;
    end else if (cnt_q == period - TW'(1)) begin
      cnt_d = '0;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && period > TW'(1) && $stable(period)) |=> !tick);
endmodule

// File: rtl/adc_corr_lane.sv
module adc_corr_lane #(
  parameter int DW = 16,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_smp,
  input  logic [GW-1:0] gain,
  input  logic [DW-1:0] offset,
  output logic          out_vld,
  output logic [DW-1:0] out_smp
);
  localparam int PW = DW + GW;
  localparam int SW = PW + 2;
  localparam int FB = GW - 1;
  localparam logic [GW-1:0] UNITY = {1'b0, {(GW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMAX = (SW'(1) <<< (DW-1)) - SW'(1);
  localparam logic signed [SW-1:0] SMIN = -(SW'(1) <<< (DW-1));

  logic signed [PW-1:0] prod_d, prod_q;
  logic signed [SW-1:0] sum, scaled;
  logic        [DW-1:0] res_d, res_q;
  logic                 s1_vld_q, s2_vld_q;

  always_comb begin
    if (gain == UNITY) prod_d = PW'(signed'(in_smp)) <<< FB;
    else               prod_d = PW'(signed'(in_smp)) * PW'(signed'(gain));
  end

  always_comb begin
    sum    = SW'(prod_q) + (SW'(signed'(offset)) <<< FB) + (SW'(1) <<< (FB-1));
    scaled = sum >>> FB;
    if (scaled > SMAX)      res_d = SMAX[DW-1:0];
    else if (scaled < SMIN) res_d = SMIN[DW-1:0];
    else                    res_d = scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= in_vld;
      s2_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prod_q <= '0;
    else if (in_vld)   prod_q <= prod_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (s1_vld_q) res_q <= res_d;
  end

  assign out_vld = s2_vld_q;
  assign out_smp = res_q;

  // R4
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && gain == UNITY && offset == '0) ##1 (offset == '0)
    |=> (out_vld && out_smp == $past(in_smp, 2)));
endmodule

// File: rtl/adc_chan_fifo.sv
module adc_chan_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, rd_q, wr_d, rd_d, occ;
  logic          full, accept, take;

  assign occ    = wr_q - rd_q;
  assign empty  = (occ == '0);
  assign full   = (occ == (AW+1)'(DEPTH));
  assign take   = pop && !empty;
  assign accept = push && (!full || take);
  assign drop   = push && !accept;
  assign dout   = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = accept ? wr_q + (AW+1)'(1) : wr_q;
    rd_d = take   ? rd_q + (AW+1)'(1) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q[AW-1:0]] <= din;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(DEPTH));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rd_q));
endmodule

// File: rtl/adc_corr_buf.sv
module adc_corr_buf
  import adc_corr_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int TW    = 32,
  parameter int RW    = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              samp_tick,
  input  logic [NCH-1:0]    adc_valid,
  input  logic [NCH*DW-1:0] adc_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [GW-1:0] UNITY = {1'b0, {(GW-1){1'b1}}};

  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  reg_grp_e       grp;
  logic [3:0]     sub;
  logic [CHW-1:0] idx;
  assign grp = reg_grp_e'(reg_addr[7:4]);
  assign sub = reg_addr[3:0];
  assign idx = reg_addr[CHW-1:0];

  logic          period_wr, ovf_clr;
  logic [TW-1:0] period_q, period_d;
  logic [NCH-1:0] ovf_q, ovf_d, lane_vld, drop, empty;
  logic [GW-1:0] gain_q [NCH];
  logic [DW-1:0] offs_q [NCH];
  logic [DW-1:0] lane_smp [NCH];
  logic [DW-1:0] head [NCH];
  logic [RW-1:0] rdata_q, rdata_d;

  assign period_wr = reg_wr && grp == GRP_CTRL && sub == CTRL_PERIOD;
  assign ovf_clr   = reg_wr && grp == GRP_CTRL && sub == CTRL_OVF;

  always_comb begin
    period_d = period_wr ? reg_wdata[TW-1:0] : period_q;
    ovf_d    = (ovf_q & ~(ovf_clr ? reg_wdata[NCH-1:0] : '0)) | drop;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      period_q <= '0;
      ovf_q    <= '0;
    end else begin
      period_q <= period_d;
      ovf_q    <= ovf_d;
    end
  end

  adc_tick_gen #(.TW(TW)) u_tick (
    .clk(clk), .rst_n(srst_n), .period(period_q), .load(period_wr), .tick(samp_tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic gain_wr, offs_wr, pop;
    assign gain_wr = reg_wr && grp == GRP_GAIN && idx == CHW'(ch);
    assign offs_wr = reg_wr && grp == GRP_OFFS && idx == CHW'(ch);
    assign pop     = reg_rd && grp == GRP_DATA && idx == CHW'(ch);

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)      gain_q[ch] <= UNITY;
      else if (gain_wr) gain_q[ch] <= reg_wdata[GW-1:0];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)      offs_q[ch] <= '0;
      else if (offs_wr) offs_q[ch] <= reg_wdata[DW-1:0];
    end

    adc_corr_lane #(.DW(DW), .GW(GW)) u_lane (
      .clk(clk), .rst_n(srst_n),
      .in_vld(adc_valid[ch]), .in_smp(adc_data[ch*DW +: DW]),
      .gain(gain_q[ch]), .offset(offs_q[ch]),
      .out_vld(lane_vld[ch]), .out_smp(lane_smp[ch])
    );

    adc_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(srst_n),
      .push(lane_vld[ch]), .pop(pop), .din(lane_smp[ch]),
      .dout(head[ch]), .empty(empty[ch]), .drop(drop[ch])
    );

    // R9
    lat_chk: assert property (@(posedge clk) disable iff (!srst_n)
      adc_valid[ch] |=> ##1 lane_vld[ch]);
    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (ovf_q[ch] && !ovf_clr) |=> ovf_q[ch]);
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      rdata_d = '0;
      unique case (grp)
        GRP_CTRL: begin
          if (sub == CTRL_PERIOD)   rdata_d = RW'(period_q);
          else if (sub == CTRL_OVF) rdata_d = RW'(ovf_q);
        end
        GRP_GAIN: rdata_d = RW'(gain_q[idx]);
        GRP_OFFS: rdata_d = RW'(offs_q[idx]);
        GRP_DATA: rdata_d = empty[idx] ? '0 : RW'(head[idx]);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: tb/tb_adc_corr_buf.sv
`timescale 1ns/1ps
module tb_adc_corr_buf;
  localparam int NCH = 16;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              samp_tick;
  logic [NCH-1:0]    adc_valid;
  logic [NCH*DW-1:0] adc_data;
  logic              reg_wr, reg_rd;
  logic [7:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  adc_corr_buf dut (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick),
    .adc_valid(adc_valid), .adc_data(adc_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {gain, offset, sample, expected}
  localparam logic [63:0] VEC [9] = '{
    {16'h7FFF, 16'h0000, 16'h1234, 16'h1234},
    {16'h4000, 16'h0000, 16'h1000, 16'h0800},
    {16'h4000, 16'h0000, 16'h0003, 16'h0002},
    {16'h4000, 16'hFFFB, 16'hFFFD, 16'hFFFA},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
    {16'h7FFF, 16'h8000, 16'h8000, 16'h8000},
    {16'h8000, 16'h0000, 16'h8000, 16'h7FFF},
    {16'h2000, 16'h0064, 16'h0400, 16'h0164},
    {16'h7FFE, 16'h0000, 16'h7FFF, 16'h7FFD}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input int ch, input logic [15:0] s);
    @(negedge clk);
    adc_valid[ch] = 1'b1; adc_data[ch*DW +: DW] = s;
    @(negedge clk);
    adc_valid[ch] = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic count_ticks(input int cycles, output int cnt);
    cnt = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (samp_tick) cnt++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0; adc_valid = '0; adc_data = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdreg(8'h13, rd); check("R1 gain reset", rd, 32'h7FFF);
    rdreg(8'h2A, rd); check("R1 offset reset", rd, 32'h0);
    rdreg(8'h00, rd); check("R1 period reset", rd, 32'h0);
    rdreg(8'h04, rd); check("R1 overflow reset", rd, 32'h0);
    rdreg(8'h35, rd); check("R1 data reset", rd, 32'h0);
    check("R10 no tick at reset", {31'b0, samp_tick}, 32'h0);

    // Vector table: R3 R4 R5 via R2 register map
    for (int i = 0; i < 9; i++) begin
      wr(8'h10 | 8'(i), {16'h0, VEC[i][63:48]});
      wr(8'h20 | 8'(i), {16'h0, VEC[i][47:32]});
      rdreg(8'h10 | 8'(i), rd); check("R2 gain readback", rd, {16'h0, VEC[i][63:48]});
      push(i, VEC[i][31:16]);
      settle();
      rdreg(8'h30 | 8'(i), rd);
      check("R3/R4/R5 corrected sample", rd, {16'h0, VEC[i][15:0]});
    end

    // R10 timer
    wr(8'h00, 32'd4);
    count_ticks(20, t); check("R10 period 4", 32'(t), 32'd5);
    rdreg(8'h00, rd); check("R2 period readback", rd, 32'd4);
    wr(8'h00, 32'd1);
    count_ticks(20, t); check("R10 period 1", 32'(t), 32'd20);
    wr(8'h00, 32'd0);
    count_ticks(20, t); check("R10 period 0 disables", 32'(t), 32'd0);

    // R7 overflow on lane 15, R6 order
    for (int i = 0; i < 17; i++) push(15, 16'(100 + i));
    settle();
    rdreg(8'h04, rd); check("R7 overflow bit", rd, 32'h8000);
    for (int i = 0; i < 16; i++) begin
      rdreg(8'h3F, rd); check("R6 fifo order", rd, 32'(100 + i));
    end
    rdreg(8'h3F, rd); check("R8 empty read", rd, 32'h0);
    rdreg(8'h3F, rd); check("R8 second empty read", rd, 32'h0);
    push(15, 16'd555);
    settle();
    rdreg(8'h3F, rd); check("R8 pointers intact", rd, 32'd555);
    rdreg(8'h04, rd); check("R7 overflow sticky", rd, 32'h8000);
    wr(8'h04, 32'h8000);
    rdreg(8'h04, rd); check("R7 overflow cleared", rd, 32'h0);

    // R9 push and pop in the same cycle on a full lane 14
    for (int i = 0; i < 16; i++) push(14, 16'(200 + i));
    settle();
    @(negedge clk);
    adc_valid[14] = 1'b1; adc_data[14*DW +: DW] = 16'd999;
    @(negedge clk);
    adc_valid[14] = 1'b0;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 8'h3E;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R9 pop on write edge", reg_rdata, 32'd200);
    settle();
    rdreg(8'h04, rd); check("R9 no overflow on concurrent pop", rd, 32'h0);
    for (int i = 1; i < 16; i++) begin
      rdreg(8'h3E, rd); check("R9 remaining order", rd, 32'(200 + i));
    end
    rdreg(8'h3E, rd); check("R9 new sample kept", rd, 32'd999);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule